// File: doc/BRIEF.md
# Real-time clock seconds counter

This block is the timekeeping core of a real-time clock. It runs directly from a 32.768 kHz timebase. A 16-bit prescaler counts every timebase cycle. A 32-bit seconds counter advances once per 32768 cycles, on the cycle where prescaler bit 14 drops from 1 to 0. A seconds alarm comparator sets a sticky alarm flag. A compensation interval counter reloads from a programmable interval at each second when it reaches zero and otherwise counts down once per second.

Software reaches every field through a simple register port. Writes take effect on the clock edge. Reads are registered, so data is returned one cycle after the read strobe. A control bit starts and stops the time counter. Three status flags report invalid time, seconds overflow and alarm. Time counts only while the enable bit is set and neither the invalid flag nor the overflow flag is set.

Register map (word addresses): 0 seconds, 1 prescaler, 2 alarm, 3 compensation, 4 control (bit 0 enable), 5 status (bit 0 invalid, bit 1 overflow, bit 2 alarm). Any other address reads as zero.

Top module: `rtc_sec_core`

## Requirements
- R1: After reset the invalid flag is set, the enable bit is clear, and the seconds, prescaler, alarm and compensation registers all read zero.
- R2: While time is counting, the prescaler advances by one on every clock, and bus writes to it are ignored.
- R3: While the enable bit is clear, a write to address 1 loads bits 15..0 into the prescaler and the prescaler holds its value; bits 31..16 of address 1 always read zero.
- R4: The seconds counter advances by one on exactly the clock where prescaler bit 14 goes from 1 to 0 (counts 0x7FFF to 0x8000 and 0xFFFF to 0x0000).
- R5: While the invalid flag or the overflow flag is set, address 1 reads zero, whatever the prescaler holds.
- R6: A write to address 0 loads the seconds counter and clears both the invalid and overflow flags, but only while the enable bit is clear; with the enable bit set the write has no effect.
- R7: When the seconds counter advances from 0xFFFFFFFF it wraps to zero, sets the overflow flag (status bit 1), and time stops counting until the flag is cleared.
- R8: The alarm flag (status bit 2) is set when the seconds counter advances while it equals the alarm value; equality alone, with no advance, does not set it.
- R9: Any write to address 2 loads the alarm value and clears the alarm flag; on the same edge the write takes priority over a flag set.
- R10: On each seconds advance the interval counter reloads from the programmed interval, and the active compensation value is loaded from the compensation setting, when it is zero; otherwise it decrements by one.
- R11: The compensation register at address 3 reads {interval counter[31:24], active value[23:16], interval[15:8], setting[7:0]}; writes load only bits 15..0, and the upper two fields are read-only.
- R12: A read strobe returns the addressed register on the read data bus in the following cycle; a write to address 4 sets the enable bit from data bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz timebase clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after bus_rd |
| alarm_flag | output | 1 | Sticky alarm flag |
| overflow_flag | output | 1 | Seconds overflow flag |
| invalid_flag | output | 1 | Time invalid flag |

## Verification
The bench preloads the prescaler just below both bit-14 falling points, so each short run crosses a second boundary. A counter that used the wrong edge or bit would then show seconds off by one. It runs the seconds counter across the all-ones wrap with the alarm set to the same value. This exposes a missing overflow stop, a wrap that fails to clear, or an alarm compared after the increment instead of before. It tries writes to the prescaler and seconds while counting and checks that both are refused. It also reads the prescaler under each flag, where a leak of the raw value shows up. Several seconds pass with a short programmed interval, so a reload at the wrong count, or a stale active value, appears in the compensation register.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int RTC_AW = 3;

  typedef enum logic [RTC_AW-1:0] {
    RA_SEC = 3'd0,
    RA_PRE = 3'd1,
    RA_ALM = 3'd2,
    RA_CMP = 3'd3,
    RA_CTL = 3'd4,
    RA_STS = 3'd5
  } rtc_reg_e;

  localparam int ST_INV = 0;
  localparam int ST_OVF = 1;
  localparam int ST_ALM = 2;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRE_W    = 16,
  parameter int TICK_BIT = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             load,
  input  logic [PRE_W-1:0] load_val,
  output logic [PRE_W-1:0] count,
  output logic             tick
);
  logic [PRE_W-1:0] nxt;

  assign nxt  = count + 1'b1;
  // a second ends where the tick bit falls on the next increment
  assign tick = run & count[TICK_BIT] & ~nxt[TICK_BIT];

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= load_val;
    else if (run)  count <= nxt;
  end
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [SEC_W-1:0] load_val,
  output logic [SEC_W-1:0] count,
  output logic             wrap
);
  assign wrap = tick & (&count);

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= load_val;
    else if (tick) count <= count + 1'b1;
  end
endmodule

// File: rtl/rtc_comp_interval.sv
module rtc_comp_interval #(
  parameter int CMP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CMP_W-1:0] interval,
  input  logic [CMP_W-1:0] setting,
  output logic [CMP_W-1:0] cic,
  output logic [CMP_W-1:0] active
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cic    <= '0;
      active <= '0;
    end else if (tick) begin
      if (cic == '0) begin
        cic    <= interval;
        active <= setting;
      end else begin
        cic    <= cic - 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_sec_core.sv
module rtc_sec_core
  import rtc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PRE_W    = 16,
  parameter int TICK_BIT = 14,
  parameter int SEC_W    = 32,
  parameter int CMP_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [RTC_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              alarm_flag,
  output logic              overflow_flag,
  output logic              invalid_flag
);
  logic             ctl_en, inv_q, ovf_q, af_q;
  logic [SEC_W-1:0] alm_q, sec;
  logic [PRE_W-1:0] pre;
  logic [CMP_W-1:0] cir_q, tcr_q, cic, tcv;
  logic             run, tick, wrap;
  logic             wr_sec, wr_pre, wr_alm, wr_cmp, wr_ctl;
  logic [DATA_W-1:0] rd_mux;

  assign run    = ctl_en & ~inv_q & ~ovf_q;
  assign wr_sec = bus_wr && (bus_addr == RA_SEC) && !ctl_en;
  assign wr_pre = bus_wr && (bus_addr == RA_PRE) && !ctl_en;
  assign wr_alm = bus_wr && (bus_addr == RA_ALM);
  assign wr_cmp = bus_wr && (bus_addr == RA_CMP);
  assign wr_ctl = bus_wr && (bus_addr == RA_CTL);

  rtc_prescaler #(.PRE_W(PRE_W), .TICK_BIT(TICK_BIT)) u_pre (
    .clk(clk), .rst(rst), .run(run), .load(wr_pre),
    .load_val(bus_wdata[PRE_W-1:0]), .count(pre), .tick(tick)
  );

  rtc_seconds #(.SEC_W(SEC_W)) u_sec (
    .clk(clk), .rst(rst), .tick(tick), .load(wr_sec),
    .load_val(bus_wdata[SEC_W-1:0]), .count(sec), .wrap(wrap)
  );

  rtc_comp_interval #(.CMP_W(CMP_W)) u_cmp (
    .clk(clk), .rst(rst), .tick(tick), .interval(cir_q),
    .setting(tcr_q), .cic(cic), .active(tcv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_en <= 1'b0;
      inv_q  <= 1'b1;
      ovf_q  <= 1'b0;
      af_q   <= 1'b0;
      alm_q  <= '0;
      cir_q  <= '0;
      tcr_q  <= '0;
    end else begin
      if (wr_ctl) ctl_en <= bus_wdata[0];
      if (wr_sec) inv_q <= 1'b0;
      if (wr_sec)    ovf_q <= 1'b0;
      else if (wrap) ovf_q <= 1'b1;
      if (wr_alm) begin
        alm_q <= bus_wdata[SEC_W-1:0];
        af_q  <= 1'b0;
      end else if (tick && (sec == alm_q)) begin
        af_q  <= 1'b1;
      end
      if (wr_cmp) begin
        cir_q <= bus_wdata[2*CMP_W-1:CMP_W];
        tcr_q <= bus_wdata[CMP_W-1:0];
      end
    end
  end

  always_comb begin
    case (bus_addr)
      RA_SEC:  rd_mux = DATA_W'(sec);
      RA_PRE:  rd_mux = (inv_q | ovf_q) ? '0 : DATA_W'(pre);
      RA_ALM:  rd_mux = DATA_W'(alm_q);
      RA_CMP:  rd_mux = DATA_W'({cic, tcv, cir_q, tcr_q});
      RA_CTL:  rd_mux = DATA_W'(ctl_en);
      RA_STS:  rd_mux = DATA_W'({af_q, ovf_q, inv_q});
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign alarm_flag    = af_q;
  assign overflow_flag = ovf_q;
  assign invalid_flag  = inv_q;
endmodule

// File: rtl/rtc_sec_core_chk.sv
module rtc_sec_core_chk
  import rtc_pkg::*;
#(
  parameter int PRE_W = 16,
  parameter int SEC_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [RTC_AW-1:0] bus_addr,
  input logic              ctl_en,
  input logic              tick,
  input logic [PRE_W-1:0]  pre,
  input logic [SEC_W-1:0]  sec,
  input logic [SEC_W-1:0]  alm,
  input logic              ovf,
  input logic              af
);
  assert_wrap_zero_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> (sec == '0));

  assert_stopped_R7: assert property (@(posedge clk) disable iff (rst)
    (ovf && !(bus_wr && bus_addr == RA_SEC)) |=> (sec == $past(sec)));

  assert_alarm_set_R8: assert property (@(posedge clk) disable iff (rst)
    (tick && sec == alm && !(bus_wr && bus_addr == RA_ALM)) |=> af);

  assert_alarm_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == RA_ALM) |=> !af);

  assert_pre_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!ctl_en && !(bus_wr && bus_addr == RA_PRE)) |=> $stable(pre));

  assert_sec_step_R4: assert property (@(posedge clk) disable iff (rst)
    tick |=> (sec == $past(sec) + 1'b1));
endmodule

bind rtc_sec_core rtc_sec_core_chk #(.PRE_W(PRE_W), .SEC_W(SEC_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .ctl_en(ctl_en), .tick(tick), .pre(pre), .sec(sec), .alm(alm_q),
  .ovf(ovf_q), .af(af_q)
);

// File: tb/rtc_sec_core_bench.sv
`timescale 1ns/1ps
module rtc_sec_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        alarm_flag, overflow_flag, invalid_flag;

  int n_chk = 0, n_bad = 0;

  // reference model state
  logic [15:0] m_pre;
  logic [31:0] m_sec, m_alm;
  logic [7:0]  m_cic, m_tcv, m_cir, m_tcr;
  logic        m_en, m_inv, m_ovf, m_af;

  always #2.5 clk = ~clk;

  rtc_sec_core u_rtc_sec_core (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .alarm_flag(alarm_flag), .overflow_flag(overflow_flag),
    .invalid_flag(invalid_flag)
  );

  task automatic model_reset();
    m_pre = '0; m_sec = '0; m_alm = '0;
    m_cic = '0; m_tcv = '0; m_cir = '0; m_tcr = '0;
    m_en = 1'b0; m_inv = 1'b1; m_ovf = 1'b0; m_af = 1'b0;
  endtask

  function automatic logic [31:0] mread(input logic [2:0] a);
    case (a)
      3'd0: return m_sec;
      3'd1: return (m_inv || m_ovf) ? 32'h0 : {16'h0, m_pre};
      3'd2: return m_alm;
      3'd3: return {m_cic, m_tcv, m_cir, m_tcr};
      3'd4: return {31'h0, m_en};
      3'd5: return {29'h0, m_af, m_ovf, m_inv};
      default: return 32'h0;
    endcase
  endfunction

  // one clock edge of the reference: counting uses pre-edge state, then writes
  task automatic model_edge(input logic w, input logic [2:0] a, input logic [31:0] d);
    logic        cnt, tk, en_old;
    logic [15:0] nxt;
    en_old = m_en;
    cnt = m_en && !m_inv && !m_ovf;
    if (cnt) begin
      nxt = m_pre + 16'd1;
      tk  = m_pre[14] && !nxt[14];
      m_pre = nxt;
      if (tk) begin
        if (m_sec == m_alm) m_af = 1'b1;
        if (m_sec == 32'hFFFF_FFFF) m_ovf = 1'b1;
        m_sec = m_sec + 32'd1;
        if (m_cic == 8'd0) begin m_cic = m_cir; m_tcv = m_tcr; end
        else m_cic = m_cic - 8'd1;
      end
    end
    if (w) begin
      case (a)
        3'd0: if (!en_old) begin m_sec = d; m_inv = 1'b0; m_ovf = 1'b0; end
        3'd1: if (!en_old) m_pre = d[15:0];
        3'd2: begin m_alm = d; m_af = 1'b0; end
        3'd3: begin m_cir = d[15:8]; m_tcr = d[7:0]; end
        3'd4: m_en = d[0];
        default: ;
      endcase
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic cyc(input logic w, input logic r, input logic [2:0] a, input logic [31:0] d,
                     output logic [31:0] rdv);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    model_edge(w, a, d);
    rdv = bus_rdata;
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    logic [31:0] junk;
    cyc(1'b1, 1'b0, a, d, junk);
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a);
    logic [31:0] exp, got;
    exp = mread(a);
    cyc(1'b0, 1'b1, a, 32'h0, got);
    check(req, got, exp);
  endtask

  task automatic run(input int n);
    logic [31:0] junk;
    wr(3'd4, 32'h1);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 3'd0, 32'h0, junk);
    wr(3'd4, 32'h0);
  endtask

  task automatic check_all();
    rd_chk("R4 seconds", 3'd0);
    rd_chk("R2 prescaler", 3'd1);
    rd_chk("R8 alarm value", 3'd2);
    rd_chk("R10 compensation", 3'd3);
    rd_chk("R12 control", 3'd4);
    rd_chk("R8 status", 3'd5);
  endtask

  initial begin
    #(5.0 * 190000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1357));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 invalid flag pin", {31'h0, invalid_flag}, 32'h1);
    check_all();
    rd_chk("R1 unmapped address", 3'd7);

    // R5 prescaler hidden while invalid
    wr(3'd1, 32'h0000_0055);
    rd_chk("R5 prescaler masked by invalid", 3'd1);
    wr(3'd0, 32'd10);
    rd_chk("R6 invalid cleared", 3'd5);
    rd_chk("R5 prescaler visible", 3'd1);

    // R3 upper bits dropped, R2 write refused while counting
    wr(3'd1, 32'hABCD_1234);
    rd_chk("R3 prescaler upper zero", 3'd1);
    wr(3'd4, 32'h1);
    wr(3'd1, 32'h0000_0000);
    wr(3'd4, 32'h0);
    rd_chk("R2 prescaler write ignored", 3'd1);
    check("R2 prescaler advanced", mread(3'd1), 32'h0000_1236);

    // R6 seconds write refused while enabled
    wr(3'd4, 32'h1);
    wr(3'd0, 32'd99);
    wr(3'd4, 32'h0);
    rd_chk("R6 seconds write ignored", 3'd0);

    // R4 both falling points of bit 14
    wr(3'd1, 32'h0000_7FFC);
    run(5);
    rd_chk("R4 tick at 7FFF", 3'd0);
    wr(3'd1, 32'h0000_FFFD);
    run(5);
    rd_chk("R4 tick at FFFF", 3'd0);
    rd_chk("R4 prescaler wrapped", 3'd1);

    // R7 overflow with alarm on the same second
    wr(3'd1, 32'h0000_7FFE);
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd2, 32'hFFFF_FFFF);
    run(3);
    check("R7 overflow pin", {31'h0, overflow_flag}, 32'h1);
    rd_chk("R7 wrapped to zero", 3'd0);
    rd_chk("R7 status overflow and alarm", 3'd5);
    rd_chk("R5 prescaler masked by overflow", 3'd1);
    run(4);
    rd_chk("R7 stopped while overflow", 3'd0);
    wr(3'd0, 32'h0);
    rd_chk("R6 overflow cleared", 3'd5);
    rd_chk("R7 prescaler held 8000", 3'd1);

    // R9 alarm write clears flag
    wr(3'd2, 32'd7);
    rd_chk("R9 alarm flag cleared", 3'd5);
    check("R9 alarm pin", {31'h0, alarm_flag}, 32'h0);

    // R8 equality without an advance
    wr(3'd0, 32'd7);
    wr(3'd1, 32'h0);
    run(6);
    rd_chk("R8 no alarm without advance", 3'd5);

    // R10/R11 interval counting over several seconds
    wr(3'd3, 32'hFFFF_03AB);
    rd_chk("R11 upper fields read-only", 3'd3);
    for (int s = 0; s < 6; s++) begin
      wr(3'd1, 32'h0000_7FF8 | (s[0] ? 32'h8000 : 32'h0));
      run(10);
      rd_chk("R10 interval counter", 3'd3);
    end

    // random mix
    for (int it = 0; it < 80; it++) begin
      int sel;
      sel = $urandom % 4;
      v = (sel == 0) ? 32'h7FF0 : (sel == 1) ? 32'hFFF0 : {16'h0, 16'($urandom)};
      wr(3'd1, v + ($urandom % 16));
      if ($urandom % 2) begin
        sel = $urandom % 3;
        wr(3'd0, (sel == 0) ? m_alm : (sel == 1) ? 32'hFFFF_FFFF : $urandom);
      end
      if ($urandom % 3 == 0) wr(3'd2, ($urandom % 2) ? m_sec : $urandom);
      if ($urandom % 4 == 0) wr(3'd3, $urandom % 32'h0000_0600);
      run($urandom % 40);
      check_all();
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule